// File: doc/BRIEF.md
# Cache Maintenance Command Engine

This block sequences maintenance operations over the tag and state storage of a small two-way set-associative cache with 16-byte lines. A command names an operation (search, invalidate, push or clear) and a scope. The scope is either the whole cache or the single line that holds a given physical address. The engine then visits the affected entries and rewrites their valid and modified bits. Whenever a modified line has to reach memory first, it raises a write-back request that carries the line address and the 128-bit line data, and it waits until memory accepts that request.

The tag, state and data storage sit inside the block as registers. A fill port loads entries so that the cache can be seeded with content. A peek port reads back the valid bit, the modified bit and the tag of any entry. Normal lookups, refills and the processor bus lie outside this block.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset, `busy`, `err`, `miss` and `wb_valid` are 0, and every entry reads back as invalid and unmodified.
- R2: Invalidate (op code 1) clears both the valid and the modified bit of each visited entry and never raises a write-back.
- R3: Push (op code 2) writes back an entry that is valid and modified, then clears only its modified bit and leaves it valid. An entry that is not both valid and modified is left untouched and is not written back.
- R4: Clear (op code 3) writes back an entry that is valid and modified and then clears its valid and modified bits. A valid entry that is not modified has its valid bit cleared and is not written back.
- R5: Op code 0 (search) changes no state. `cmd_all`=1 selects the whole cache, and `cmd_all`=0 selects the single line addressed by `cmd_addr`.
- R6: A single-line command ignores address bits [3:0], takes the set from bits [11:4] and the tag from bits [31:12], and searches both ways. Way 0 wins if both ways match. Only the entry that matches and is valid is changed, and the other way of the set keeps its state.
- R7: A single-line command that finds no valid matching tag changes no state and sets `miss` to 1. An accepted go clears `miss`, so `miss` is never 1 while `busy` is 1.
- R8: A whole-cache command visits the sets in ascending order and, within each set, way 0 before way 1. Its write-backs therefore leave in that order.
- R9: `busy` is 1 from the cycle after an accepted go until the command finishes. Without write-backs, a whole-cache command keeps `busy` high for 2*SETS cycles, a single-line hit for 2 cycles and a single-line miss for 1 cycle.
- R10: While `wb_valid` is 1 and `wb_ready` is 0, `wb_valid`, `wb_addr` and `wb_data` hold steady and the engine does not advance. `wb_addr` is the line address {tag, set, 4'b0}, and `wb_data` is the stored line.
- R11: A go that arrives while `busy` is 1 is ignored, and the running command completes unchanged. `err` is then set to 1 and stays at 1 until reset.
- R12: When the engine is idle, `fill_en` writes the entry selected by `fill_way` and by `fill_addr` bits [11:4] with the tag, valid bit, modified bit and data supplied. The peek port shows an entry's state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Start pulse for a command |
| cmd_op | input | 2 | 0 search, 1 invalidate, 2 push, 3 clear |
| cmd_all | input | 1 | 1 = whole cache, 0 = one line |
| cmd_addr | input | ADDR_W | Physical address for a single-line command |
| busy | output | 1 | Command in progress |
| miss | output | 1 | Last single-line command found no match |
| err | output | 1 | Sticky flag for a go received while busy |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_addr | output | ADDR_W | Line address of the write-back |
| wb_data | output | DATA_W | Line data of the write-back |
| fill_en | input | 1 | Load one entry (idle only) |
| fill_way | input | 1 | Way to load |
| fill_addr | input | ADDR_W | Address that supplies the set and the tag |
| fill_valid | input | 1 | Valid bit to load |
| fill_dirty | input | 1 | Modified bit to load |
| fill_data | input | DATA_W | Line data to load |
| pk_way | input | 1 | Way to observe |
| pk_set | input | IDX_W | Set to observe |
| pk_valid | output | 1 | Observed valid bit |
| pk_dirty | output | 1 | Observed modified bit |
| pk_tag | output | TAG_W | Observed tag |

## Verification
The case that is hardest to reach from the ports is a whole-cache walk that finds several modified lines spread across distant sets and both ways, with memory holding each write-back for some cycles. The stimulus fills set 0 way 1, set 10 in both ways and set 255 way 0 with chosen states. A responder delays every acceptance and records each request, so the bench can check both the order of the write-backs and their stability while they wait. A second go is injected in the middle of a long whole-cache push, so the ignored command and the sticky error can be seen together.

// File: rtl/cme_pkg.sv
package cme_pkg;
    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        OP_SEARCH = 2'd0,
        OP_INVAL  = 2'd1,
        OP_PUSH   = 2'd2,
        OP_CLEAR  = 2'd3
    } cme_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_STEP,
        ST_WB
    } cme_st_e;
endpackage

// File: rtl/cme_store.sv
module cme_store #(
    parameter int SETS   = 256,
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic              fill_way,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_valid,
    input  logic              fill_dirty,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic              upd_way,
    input  logic [IDX_W-1:0]  upd_set,
    input  logic              upd_valid,
    input  logic              upd_dirty,
    input  logic              cur_way,
    input  logic [IDX_W-1:0]  cur_set,
    output logic              cur_valid,
    output logic              cur_dirty,
    output logic [TAG_W-1:0]  cur_tag,
    output logic [DATA_W-1:0] cur_data,
    input  logic [IDX_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic [cme_pkg::NUM_WAYS-1:0] lk_hit,
    input  logic              pk_way,
    input  logic [IDX_W-1:0]  pk_set,
    output logic              pk_valid,
    output logic              pk_dirty,
    output logic [TAG_W-1:0]  pk_tag
);
    localparam int NW = cme_pkg::NUM_WAYS;

    logic [SETS-1:0]   valid_q [NW];
    logic [SETS-1:0]   dirty_q [NW];
    logic [TAG_W-1:0]  tag_q   [NW][SETS];
    logic [DATA_W-1:0] data_q  [NW][SETS];

    // State bits: the engine's update has priority over a fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                valid_q[w] <= '0;
                dirty_q[w] <= '0;
            end
        end else if (upd_en) begin
            valid_q[upd_way][upd_set] <= upd_valid;
            dirty_q[upd_way][upd_set] <= upd_dirty;
        end else if (fill_en) begin
            valid_q[fill_way][fill_set] <= fill_valid;
            dirty_q[fill_way][fill_set] <= fill_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_way][fill_set]  <= fill_tag;
            data_q[fill_way][fill_set] <= fill_data;
        end
    end

    assign cur_valid = valid_q[cur_way][cur_set];
    assign cur_dirty = dirty_q[cur_way][cur_set];
    assign cur_tag   = tag_q[cur_way][cur_set];
    assign cur_data  = data_q[cur_way][cur_set];

    for (genvar w = 0; w < NW; w++) begin : g_cmp
        assign lk_hit[w] = valid_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);
    end

    assign pk_valid = valid_q[pk_way][pk_set];
    assign pk_dirty = dirty_q[pk_way][pk_set];
    assign pk_tag   = tag_q[pk_way][pk_set];
endmodule

// File: rtl/cme_seq.sv
module cme_seq
    import cme_pkg::*;
#(
    parameter int SETS  = 256,
    parameter int IDX_W = 8,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_all,
    input  logic [IDX_W-1:0] cmd_set,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic [NUM_WAYS-1:0] lk_hit,
    input  logic             cur_valid,
    input  logic             cur_dirty,
    input  logic             wb_ready,
    output logic             busy,
    output logic             miss,
    output logic             err,
    output logic             wb_valid,
    output logic             cur_way,
    output logic [IDX_W-1:0] cur_set,
    output logic [TAG_W-1:0] lk_tag,
    output logic             upd_en,
    output logic             upd_valid,
    output logic             upd_dirty
);
    localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

    typedef struct packed {
        cme_st_e          st;
        cme_op_e          op;
        logic             all;
        logic [IDX_W-1:0] set;
        logic             way;
        logic [TAG_W-1:0] tag;
        logic             miss;
        logic             err;
    } seq_t;

    seq_t q, d;
    logic needs_wb;
    logic apply;

    always_comb begin
        d         = q;
        apply     = 1'b0;
        wb_valid  = 1'b0;
        upd_en    = 1'b0;
        upd_valid = cur_valid;
        upd_dirty = cur_dirty;
        needs_wb  = (q.op == OP_PUSH || q.op == OP_CLEAR) && cur_valid && cur_dirty;

        if (cmd_go && q.st != ST_IDLE) d.err = 1'b1;

        unique case (q.st)
            ST_IDLE: if (cmd_go) begin
                d.op   = cme_op_e'(cmd_op);
                d.all  = cmd_all;
                d.set  = cmd_all ? '0 : cmd_set;
                d.way  = 1'b0;
                d.tag  = cmd_tag;
                d.miss = 1'b0;
                d.st   = cmd_all ? ST_STEP : ST_LOOK;
            end
            ST_LOOK: begin
                if (lk_hit != '0) begin
                    d.way = ~lk_hit[0];
                    d.st  = ST_STEP;
                end else begin
                    d.miss = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            ST_STEP: begin
                if (needs_wb) d.st = ST_WB;
                else          apply = 1'b1;
            end
            ST_WB: begin
                wb_valid = 1'b1;
                apply    = wb_ready;
            end
            default: d.st = ST_IDLE;
        endcase

        if (apply) begin
            unique case (q.op)
                OP_INVAL: begin
                    upd_en = 1'b1; upd_valid = 1'b0; upd_dirty = 1'b0;
                end
                OP_CLEAR: begin
                    upd_en = 1'b1; upd_valid = 1'b0; upd_dirty = 1'b0;
                end
                OP_PUSH: begin
                    upd_en = (q.st == ST_WB); upd_dirty = 1'b0;
                end
                default: upd_en = 1'b0;
            endcase
            if (!q.all || (q.set == LAST_SET && q.way)) begin
                d.st = ST_IDLE;
            end else begin
                d.st  = ST_STEP;
                d.way = ~q.way;
                if (q.way) d.set = q.set + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_SEARCH, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign miss    = q.miss;
    assign err     = q.err;
    assign cur_way = q.way;
    assign cur_set = q.set;
    assign lk_tag  = q.tag;
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine #(
    parameter  int ADDR_W     = 32,
    parameter  int LINE_BYTES = 16,
    parameter  int SETS       = 256,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int IDX_W      = $clog2(SETS),
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W,
    localparam int DATA_W     = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_all,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              miss,
    output logic              err,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              fill_en,
    input  logic              fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic              fill_dirty,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              pk_way,
    input  logic [IDX_W-1:0]  pk_set,
    output logic              pk_valid,
    output logic              pk_dirty,
    output logic [TAG_W-1:0]  pk_tag
);
    logic                 cur_way, cur_valid, cur_dirty;
    logic [IDX_W-1:0]     cur_set;
    logic [TAG_W-1:0]     cur_tag, lk_tag;
    logic [cme_pkg::NUM_WAYS-1:0] lk_hit;
    logic                 upd_en, upd_valid, upd_dirty;
    logic                 unused_off;

    assign unused_off = ^{cmd_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

    cme_seq #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_op    (cmd_op),
        .cmd_all   (cmd_all),
        .cmd_set   (cmd_addr[OFF_W +: IDX_W]),
        .cmd_tag   (cmd_addr[ADDR_W-1 -: TAG_W]),
        .lk_hit    (lk_hit),
        .cur_valid (cur_valid),
        .cur_dirty (cur_dirty),
        .wb_ready  (wb_ready),
        .busy      (busy),
        .miss      (miss),
        .err       (err),
        .wb_valid  (wb_valid),
        .cur_way   (cur_way),
        .cur_set   (cur_set),
        .lk_tag    (lk_tag),
        .upd_en    (upd_en),
        .upd_valid (upd_valid),
        .upd_dirty (upd_dirty)
    );

    cme_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_en && !busy),
        .fill_way   (fill_way),
        .fill_set   (fill_addr[OFF_W +: IDX_W]),
        .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
        .fill_valid (fill_valid),
        .fill_dirty (fill_dirty),
        .fill_data  (fill_data),
        .upd_en     (upd_en),
        .upd_way    (cur_way),
        .upd_set    (cur_set),
        .upd_valid  (upd_valid),
        .upd_dirty  (upd_dirty),
        .cur_way    (cur_way),
        .cur_set    (cur_set),
        .cur_valid  (cur_valid),
        .cur_dirty  (cur_dirty),
        .cur_tag    (cur_tag),
        .cur_data   (wb_data),
        .lk_set     (cur_set),
        .lk_tag     (lk_tag),
        .lk_hit     (lk_hit),
        .pk_way     (pk_way),
        .pk_set     (pk_set),
        .pk_valid   (pk_valid),
        .pk_dirty   (pk_dirty),
        .pk_tag     (pk_tag)
    );

    assign wb_addr = {cur_tag, cur_set, {OFF_W{1'b0}}};
endmodule

// File: rtl/cme_checker.sv
module cme_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_go,
    input logic              busy,
    input logic              miss,
    input logic              err,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data
);
    p_wb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

    p_wb_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> busy);

    p_busy_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_go) |=> busy);

    p_err_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_go) |=> err);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_no_miss_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !miss);
endmodule

bind cache_maint_engine cme_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_go   (cmd_go),
    .busy     (busy),
    .miss     (miss),
    .err      (err),
    .wb_valid (wb_valid),
    .wb_ready (wb_ready),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data)
);

// File: tb/tb_cache_maint_engine.sv
module tb_cache_maint_engine;
    localparam int SETS  = 256;
    localparam int STALL = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_go = 1'b0;
    logic [1:0]   cmd_op = 2'd0;
    logic         cmd_all = 1'b0;
    logic [31:0]  cmd_addr = '0;
    logic         busy, miss, err, wb_valid;
    logic         wb_ready = 1'b0;
    logic [31:0]  wb_addr;
    logic [127:0] wb_data;
    logic         fill_en = 1'b0, fill_way = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0;
    logic [31:0]  fill_addr = '0;
    logic [127:0] fill_data = '0;
    logic         pk_way = 1'b0;
    logic [7:0]   pk_set = '0;
    logic         pk_valid, pk_dirty;
    logic [19:0]  pk_tag;

    cache_maint_engine dut (.*);

    initial forever #5 clk = ~clk;

    int n_run = 0, n_fail = 0;
    int wb_n = 0, stab_err = 0, wait_ctr = 0;
    logic [31:0]  wb_log_addr [16];
    logic [127:0] wb_log_data [16];
    logic [31:0]  hold_addr;
    logic [127:0] hold_data;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory side: accept each write-back after STALL waiting cycles
    initial forever begin
        @(negedge clk);
        if (wb_ready) begin
            wb_ready = 1'b0;
            wait_ctr = 0;
        end else if (wb_valid) begin
            if (wait_ctr == 0) begin
                hold_addr = wb_addr;
                hold_data = wb_data;
            end else if (wb_addr !== hold_addr || wb_data !== hold_data) begin
                stab_err++;
            end
            if (wait_ctr == STALL) begin
                wb_ready = 1'b1;
                if (wb_n < 16) begin
                    wb_log_addr[wb_n] = wb_addr;
                    wb_log_data[wb_n] = wb_data;
                end
                wb_n++;
            end else begin
                wait_ctr++;
            end
        end
    end

    task automatic fill(input logic w, input logic [31:0] a, input logic v, input logic m,
                        input logic [127:0] dat);
        @(negedge clk);
        fill_en = 1'b1; fill_way = w; fill_addr = a;
        fill_valid = v; fill_dirty = m; fill_data = dat;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic peek(input logic w, input int s, output logic v, output logic m,
                        output logic [19:0] t);
        pk_way = w; pk_set = 8'(s);
        #1;
        v = pk_valid; m = pk_dirty; t = pk_tag;
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic all, input logic [31:0] a,
                           output int cyc);
        @(negedge clk);
        cmd_go = 1'b1; cmd_op = op; cmd_all = all; cmd_addr = a;
        @(negedge clk);
        cmd_go = 1'b0;
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic       fv;
        logic       fd;
        logic       way;
        logic [1:0] op;
        logic       ev;
        logic       em;
        logic       ewb;
        logic       emiss;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 invalidate dirty
        '{1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 push dirty
        '{1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 push clean
        '{1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 clear dirty
        '{1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 clear clean
        '{1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 invalid entry misses
        '{1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 search no change
        '{1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1}   // R7 miss leaves state
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic v, m;
        logic [19:0] t;
        int cyc;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 err", err, 0);
        check("R1 miss", miss, 0);
        check("R1 wb_valid", wb_valid, 0);
        peek(1'b0, 0, v, m, t);   check("R1 entry", {v, m}, 0);
        peek(1'b1, 255, v, m, t); check("R1 entry", {v, m}, 0);
        rst_n = 1'b1;

        // R12: fill and peek
        fill(1'b1, {20'h0BEEF, 8'd200, 4'h0}, 1'b1, 1'b1, 128'h5);
        peek(1'b1, 200, v, m, t);
        check("R12 fill state", {v, m}, 2'b11);
        check("R12 fill tag", t, 20'h0BEEF);

        // table of single-line commands (R2 R3 R4 R5 R6 R7 R10)
        for (int i = 0; i < 8; i++) begin
            int s;
            logic [19:0]  tg;
            logic [127:0] dat;
            s   = i * 5 + 3;
            tg  = 20'h12340 + 20'(i);
            dat = {4{32'hC0DE0000 + 32'(i)}};
            fill(VEC[i].way, {tg, 8'(s), 4'h0}, VEC[i].fv, VEC[i].fd, dat);
            fill(~VEC[i].way, {20'h00ABC, 8'(s), 4'h0}, 1'b1, 1'b1, 128'h1);
            wb_n = 0;
            run_cmd(VEC[i].op, 1'b0, {tg, 8'(s), 4'hB}, cyc);
            peek(VEC[i].way, s, v, m, t);
            check($sformatf("R2/R3/R4 vec%0d target state", i), {v, m}, {VEC[i].ev, VEC[i].em});
            peek(~VEC[i].way, s, v, m, t);
            check($sformatf("R6 vec%0d other way", i), {v, m, t}, {2'b11, 20'h00ABC});
            check($sformatf("R10 vec%0d write-back count", i), wb_n, VEC[i].ewb);
            check($sformatf("R7 vec%0d miss", i), miss, VEC[i].emiss);
            if (VEC[i].ewb) begin
                check($sformatf("R10 vec%0d wb addr", i), wb_log_addr[0], {tg, 8'(s), 4'h0});
                check($sformatf("R10 vec%0d wb data", i), wb_log_data[0], dat);
            end
            if (VEC[i].emiss) check("R9 miss busy cycles", cyc, 1);
            else if (!VEC[i].ewb) check("R9 hit busy cycles", cyc, 2);
        end

        // R6: both ways match, way 0 wins
        fill(1'b0, {20'h07777, 8'd99, 4'h0}, 1'b1, 1'b0, 128'h2);
        fill(1'b1, {20'h07777, 8'd99, 4'h0}, 1'b1, 1'b0, 128'h3);
        run_cmd(2'd1, 1'b0, {20'h07777, 8'd99, 4'h7}, cyc);
        peek(1'b0, 99, v, m, t); check("R6 way0 priority", v, 0);
        peek(1'b1, 99, v, m, t); check("R6 way1 kept", v, 1);

        // R2 R9: invalidate whole cache, exact duration, no write-back
        wb_n = 0;
        run_cmd(2'd1, 1'b1, 32'h0, cyc);
        check("R9 whole-cache busy cycles", cyc, 2 * SETS);
        check("R2 no write-back", wb_n, 0);
        peek(1'b1, 200, v, m, t); check("R2 whole invalidate", {v, m}, 0);
        peek(1'b1, 99, v, m, t);  check("R2 whole invalidate", {v, m}, 0);

        // R8 R4: whole clear, write-back order
        fill(1'b1, {20'h00444, 8'd255, 4'h0} ^ 32'h0, 1'b0, 1'b0, 128'h0);
        fill(1'b0, {20'h00444, 8'd255, 4'h0}, 1'b1, 1'b1, 128'h44);
        fill(1'b1, {20'h00111, 8'd0, 4'h0}, 1'b1, 1'b1, 128'h11);
        fill(1'b0, {20'h00222, 8'd10, 4'h0}, 1'b1, 1'b0, 128'h22);
        fill(1'b1, {20'h00333, 8'd10, 4'h0}, 1'b1, 1'b1, 128'h33);
        wb_n = 0;
        run_cmd(2'd3, 1'b1, 32'h0, cyc);
        check("R8 write-back count", wb_n, 3);
        check("R8 first write-back", wb_log_addr[0], {20'h00111, 8'd0, 4'h0});
        check("R8 second write-back", wb_log_addr[1], {20'h00333, 8'd10, 4'h0});
        check("R8 third write-back", wb_log_addr[2], {20'h00444, 8'd255, 4'h0});
        check("R10 whole wb data", wb_log_data[2], 128'h44);
        peek(1'b0, 10, v, m, t);  check("R4 clean entry cleared", {v, m}, 0);
        peek(1'b0, 255, v, m, t); check("R4 dirty entry cleared", {v, m}, 0);
        check("R11 no error yet", err, 0);

        // R11 R3: go during a whole push is ignored, err sticky
        fill(1'b0, {20'h00555, 8'd7, 4'h0}, 1'b1, 1'b1, 128'h55);
        fill(1'b1, {20'h00666, 8'd7, 4'h0}, 1'b1, 1'b0, 128'h66);
        wb_n = 0;
        @(negedge clk);
        cmd_go = 1'b1; cmd_op = 2'd2; cmd_all = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        repeat (5) @(negedge clk);
        cmd_go = 1'b1; cmd_op = 2'd1; cmd_all = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
        check("R11 err set", err, 1);
        check("R3 whole push write-backs", wb_n, 1);
        check("R3 whole push addr", wb_log_addr[0], {20'h00555, 8'd7, 4'h0});
        peek(1'b0, 7, v, m, t); check("R3/R11 pushed stays valid", {v, m}, 2'b10);
        peek(1'b1, 7, v, m, t); check("R3/R11 clean untouched", {v, m}, 2'b10);
        repeat (3) @(negedge clk);
        check("R11 err sticky", err, 1);
        check("R10 write-back stability", stab_err, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule